// File: doc/BRIEF.md
# DDR Data-Phase Sequencer

This block runs the data half of every DDR SDRAM access. A separate command scheduler issues row and column commands. When it raises `data_en`, this sequencer takes over the data pins, and it does so while the scheduler goes on issuing commands.

For a write, it turns on the DQ and DQS output drivers after a one-cycle strobe preamble. It then splits each system-width word into two DDR beats: the upper half goes first and the lower half second. It also turns byte enables into data masks. It signals completion only once write recovery has elapsed.

For a read, it waits the configured CAS latency and then opens a read window for the capture registers. The strobe captured from the memory feeds the read FIFO's write enable. Each word that appears at the FIFO output is popped and acknowledged toward the bus.

A pair-beat counter finds the last clock of each burst. If the scheduler flags a pending operation at that point, the sequencer moves straight into the next read or write burst. It does not pass through its completion state. When DQS is not driven, the strobe output sits at the level of the board's pull resistors.

Top module: `ddr_data_phase_ctrl`

## Requirements
- R1: While the sequencer is not writing, both driver enables `dq_oe_n` and `dqs_oe_n` are high (drivers off) and `dqs_o` equals the `DQS_PULL_UP` parameter (0 = pulled down, 1 = pulled up). This also holds after reset.
- R2: Suppose `data_en` is sampled high with `op_is_read` = 1 at clock edge p. Then `rd_data_en` is high from edge p+`CAS_LAT` (`CAS_LAT` is 2 or 3) for `BURST_LEN`/2 consecutive cycles, and the DQ drivers stay off.
- R3: Suppose `data_en` is sampled high with `op_is_read` = 0 at edge q. Then for the `BURST_LEN`/2 cycles from edge q, `dq_oe_n` and `dqs_oe_n` are low, `dqs_o` is 1 and `wr_beat_ack` is high.
- R4: In the cycle before a write burst begins, `dqs_oe_n` is already low, `dqs_o` is 0 and `dq_oe_n` is still high. This forms the write preamble.
- R5: During a write cycle, `dq_hi` carries `wr_data[SYS_DW-1:SYS_DW/2]` (first beat) and `dq_lo` carries `wr_data[SYS_DW/2-1:0]` (second beat). `wr_be[i]` enables byte `wr_data[8i+7:8i]`, and the mask bit for that byte is its inverse. `dm_hi` holds the masks of the upper bytes and `dm_lo` those of the lower bytes.
- R6: `burst_end` is high exactly in the last cycle of each read or write burst. `BURST_LEN` is 2, 4 or 8 beats, which is 1, 2 or 4 cycles.
- R7: If `pend_valid` is high in a burst's last cycle, the next cycle starts a new burst with no gap. The new burst is a read if `pend_is_read` = 1 and a write otherwise, and `xfer_done` is not raised in between.
- R8: `xfer_done` pulses for exactly one cycle. After a write burst with nothing pending, the pulse falls in the `TWR_CYC`-th cycle after the burst's last cycle. After a read burst, it falls in the first cycle after the burst.
- R9: `rd_fifo_push` follows `dqs_cap` while the block is not driving DQS, and is held low whenever `dqs_oe_n` is low.
- R10: `rd_fifo_pop` is high in every cycle in which `rd_fifo_empty` is low. One cycle after each pop, `rd_ack` is high and `rd_data` holds the popped word. Otherwise `rd_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| data_en | input | 1 | Start of a data phase from the command scheduler, honoured when idle |
| op_is_read | input | 1 | Kind of the started phase: 1 read, 0 write |
| pend_valid | input | 1 | A further burst is queued |
| pend_is_read | input | 1 | Kind of the queued burst: 1 read, 0 write |
| burst_end | output | 1 | Last cycle of the current burst |
| xfer_done | output | 1 | Data phase finished, including write recovery |
| wr_data | input | SYS_DW | Write word for the current cycle |
| wr_be | input | SYS_DW/8 | Byte enables of the write word, active high |
| wr_beat_ack | output | 1 | Write word consumed this cycle |
| dq_hi | output | SYS_DW/2 | First DDR beat to the output register |
| dq_lo | output | SYS_DW/2 | Second DDR beat to the output register |
| dm_hi | output | SYS_DW/16 | Data masks of the first beat |
| dm_lo | output | SYS_DW/16 | Data masks of the second beat |
| dq_oe_n | output | 1 | DQ output enable, low drives |
| dqs_oe_n | output | 1 | DQS output enable, low drives |
| dqs_o | output | 1 | DQS level: strobe on, preamble 0, or pull level |
| rd_data_en | output | 1 | Read window for capture registers |
| dqs_cap | input | 1 | Strobe captured on the read clock |
| rd_fifo_push | output | 1 | Read FIFO write enable |
| rd_fifo_empty | input | 1 | Read FIFO empty flag |
| rd_fifo_data | input | SYS_DW | Read FIFO output word |
| rd_fifo_pop | output | 1 | Read FIFO read enable |
| rd_ack | output | 1 | Read data acknowledge toward the bus |
| rd_data | output | SYS_DW | Acknowledged read word |

## Verification
The bench instantiates the sequencer twice, once with CAS latency 2 and pull-down DQS and once with latency 3 and pull-up DQS. An off-by-one in the latency counter would therefore move one instance's read window visibly. The bench chains a read into a read and a write into a read; a design that fell back through its completion state would show a gap in the window and a spurious `xfer_done`. It times the write completion against the recovery count, so a pulse taken at burst end would be flagged. It also probes the preamble cycle, the beat and mask ordering, and strobe capture during a write: a missing preamble, swapped halves or un-inverted masks, or a FIFO fed by the block's own strobe would each fail a check.

// File: rtl/ddr_dp_pkg.sv
package ddr_dp_pkg;

   typedef enum logic [2:0] {
      DP_IDLE    = 3'd0,
      DP_WAIT_CL = 3'd1,
      DP_RD      = 3'd2,
      DP_WR      = 3'd3,
      DP_DONE    = 3'd4
   } dp_state_e;

endpackage

// File: rtl/ddr_dp_fsm.sv
module ddr_dp_fsm
   import ddr_dp_pkg::*;
#(
   parameter int CAS_LAT   = 2,
   parameter int BURST_LEN = 4,
   parameter int TWR_CYC   = 3
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      data_en,
   input  logic      op_is_read,
   input  logic      pend_valid,
   input  logic      pend_is_read,
   output dp_state_e state_o,
   output logic      burst_end_o,
   output logic      xfer_done_o,
   output logic      wr_next_o
);

   localparam int NPAIR  = BURST_LEN / 2;
   localparam int PAIR_W = (NPAIR > 1) ? $clog2(NPAIR) : 1;
   localparam int REC_W  = $clog2(TWR_CYC + 1);
   localparam logic [PAIR_W-1:0] PAIR_LAST = PAIR_W'(NPAIR - 1);
   localparam logic [1:0]        CL_LAST   = 2'(CAS_LAT - 1);
   localparam logic [REC_W-1:0]  REC_LOAD  = REC_W'(TWR_CYC - 1);

   dp_state_e         state_q, state_d;
   logic [PAIR_W-1:0] pair_q;
   logic [1:0]        wait_q;
   logic [REC_W-1:0]  rec_q;
   logic              in_burst;

   assign in_burst    = (state_q == DP_RD) || (state_q == DP_WR);
   assign burst_end_o = in_burst && (pair_q == PAIR_LAST);
   assign xfer_done_o = (state_q == DP_DONE) && (rec_q == '0);
   assign wr_next_o   = (state_d == DP_WR) && (state_q != DP_WR);
   assign state_o     = state_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         DP_IDLE:    if (data_en) state_d = op_is_read ? DP_WAIT_CL : DP_WR;
         DP_WAIT_CL: if (wait_q == CL_LAST) state_d = DP_RD;
         DP_RD, DP_WR: begin
            if (burst_end_o) begin
               if (pend_valid) state_d = pend_is_read ? DP_RD : DP_WR;
               else            state_d = DP_DONE;
            end
         end
         DP_DONE:    if (rec_q == '0) state_d = DP_IDLE;
         default:    state_d = DP_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= DP_IDLE;
         pair_q  <= '0;
         wait_q  <= '0;
         rec_q   <= '0;
      end else begin
         state_q <= state_d;
         if (in_burst && !burst_end_o) pair_q <= pair_q + 1'b1;
         else                          pair_q <= '0;
         if (state_q == DP_WAIT_CL) wait_q <= wait_q + 1'b1;
         else                       wait_q <= '0;
         if (burst_end_o)
            rec_q <= (state_q == DP_WR) ? REC_LOAD : '0;
         else if ((state_q == DP_DONE) && (rec_q != '0))
            rec_q <= rec_q - 1'b1;
      end
   end

endmodule

// File: rtl/ddr_dp_wr_path.sv
module ddr_dp_wr_path #(
   parameter int SYS_DW      = 64,
   parameter bit DQS_PULL_UP = 1'b0
) (
   input  logic                  wr_active,
   input  logic                  wr_preamble,
   input  logic [SYS_DW-1:0]     wr_data,
   input  logic [SYS_DW/8-1:0]   wr_be,
   output logic [SYS_DW/2-1:0]   dq_hi,
   output logic [SYS_DW/2-1:0]   dq_lo,
   output logic [SYS_DW/16-1:0]  dm_hi,
   output logic [SYS_DW/16-1:0]  dm_lo,
   output logic                  dq_oe_n,
   output logic                  dqs_oe_n,
   output logic                  dqs_o
);

   localparam int DQ_W   = SYS_DW / 2;
   localparam int BYTES  = SYS_DW / 8;
   localparam int HALF_B = BYTES / 2;

   logic [BYTES-1:0] lane_mask;
   logic             park_lvl;

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign lane_mask[g] = wr_active & ~wr_be[g];
   end

   if (DQS_PULL_UP) begin : g_park_hi
      assign park_lvl = 1'b1;
   end else begin : g_park_lo
      assign park_lvl = 1'b0;
   end

   assign dq_hi    = wr_active ? wr_data[SYS_DW-1:DQ_W] : '0;
   assign dq_lo    = wr_active ? wr_data[DQ_W-1:0]      : '0;
   assign dm_hi    = lane_mask[BYTES-1:HALF_B];
   assign dm_lo    = lane_mask[HALF_B-1:0];
   assign dq_oe_n  = ~wr_active;
   assign dqs_oe_n = ~(wr_active | wr_preamble);
   assign dqs_o    = wr_active ? 1'b1 : (wr_preamble ? 1'b0 : park_lvl);

endmodule

// File: rtl/ddr_dp_rd_path.sv
module ddr_dp_rd_path #(
   parameter int SYS_DW = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dqs_cap,
   input  logic              dqs_drv_n,
   input  logic              fifo_empty,
   input  logic [SYS_DW-1:0] fifo_data,
   output logic              fifo_push,
   output logic              fifo_pop,
   output logic              rd_ack,
   output logic [SYS_DW-1:0] rd_data
);

   assign fifo_push = dqs_cap & dqs_drv_n;
   assign fifo_pop  = ~fifo_empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_ack  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_ack <= fifo_pop;
         if (fifo_pop) rd_data <= fifo_data;
      end
   end

endmodule

// File: rtl/ddr_data_phase_ctrl.sv
module ddr_data_phase_ctrl
   import ddr_dp_pkg::*;
#(
   parameter int SYS_DW      = 64,
   parameter int BURST_LEN   = 4,
   parameter int CAS_LAT     = 2,
   parameter int TWR_CYC     = 3,
   parameter bit DQS_PULL_UP = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  data_en,
   input  logic                  op_is_read,
   input  logic                  pend_valid,
   input  logic                  pend_is_read,
   output logic                  burst_end,
   output logic                  xfer_done,
   input  logic [SYS_DW-1:0]     wr_data,
   input  logic [SYS_DW/8-1:0]   wr_be,
   output logic                  wr_beat_ack,
   output logic [SYS_DW/2-1:0]   dq_hi,
   output logic [SYS_DW/2-1:0]   dq_lo,
   output logic [SYS_DW/16-1:0]  dm_hi,
   output logic [SYS_DW/16-1:0]  dm_lo,
   output logic                  dq_oe_n,
   output logic                  dqs_oe_n,
   output logic                  dqs_o,
   output logic                  rd_data_en,
   input  logic                  dqs_cap,
   output logic                  rd_fifo_push,
   input  logic                  rd_fifo_empty,
   input  logic [SYS_DW-1:0]     rd_fifo_data,
   output logic                  rd_fifo_pop,
   output logic                  rd_ack,
   output logic [SYS_DW-1:0]     rd_data
);

   if (!(CAS_LAT == 2 || CAS_LAT == 3)) begin : g_bad_cas
      $error("CAS_LAT must be 2 or 3");
   end
   if (!(BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_bl
      $error("BURST_LEN must be 2, 4 or 8");
   end
   if ((SYS_DW % 16) != 0) begin : g_bad_dw
      $error("SYS_DW must be a multiple of 16");
   end
   if (TWR_CYC < 1) begin : g_bad_twr
      $error("TWR_CYC must be at least 1");
   end

   dp_state_e st;
   logic      wr_next;

   ddr_dp_fsm #(
      .CAS_LAT   (CAS_LAT),
      .BURST_LEN (BURST_LEN),
      .TWR_CYC   (TWR_CYC)
   ) u_fsm (
      .clk          (clk),
      .rst          (rst),
      .data_en      (data_en),
      .op_is_read   (op_is_read),
      .pend_valid   (pend_valid),
      .pend_is_read (pend_is_read),
      .state_o      (st),
      .burst_end_o  (burst_end),
      .xfer_done_o  (xfer_done),
      .wr_next_o    (wr_next)
   );

   assign wr_beat_ack = (st == DP_WR);
   assign rd_data_en  = (st == DP_RD);

   ddr_dp_wr_path #(
      .SYS_DW      (SYS_DW),
      .DQS_PULL_UP (DQS_PULL_UP)
   ) u_wr (
      .wr_active   (wr_beat_ack),
      .wr_preamble (wr_next),
      .wr_data     (wr_data),
      .wr_be       (wr_be),
      .dq_hi       (dq_hi),
      .dq_lo       (dq_lo),
      .dm_hi       (dm_hi),
      .dm_lo       (dm_lo),
      .dq_oe_n     (dq_oe_n),
      .dqs_oe_n    (dqs_oe_n),
      .dqs_o       (dqs_o)
   );

   ddr_dp_rd_path #(
      .SYS_DW (SYS_DW)
   ) u_rd (
      .clk        (clk),
      .rst        (rst),
      .dqs_cap    (dqs_cap),
      .dqs_drv_n  (dqs_oe_n),
      .fifo_empty (rd_fifo_empty),
      .fifo_data  (rd_fifo_data),
      .fifo_push  (rd_fifo_push),
      .fifo_pop   (rd_fifo_pop),
      .rd_ack     (rd_ack),
      .rd_data    (rd_data)
   );

endmodule

// File: rtl/ddr_data_phase_ctrl_chk.sv
module ddr_data_phase_ctrl_chk #(
   parameter bit DQS_PULL_UP = 1'b0
) (
   input logic clk,
   input logic rst,
   input logic dq_oe_n,
   input logic dqs_oe_n,
   input logic dqs_o,
   input logic rd_data_en,
   input logic burst_end,
   input logic xfer_done,
   input logic wr_beat_ack,
   input logic rd_fifo_push,
   input logic rd_fifo_pop,
   input logic rd_ack
);

   // R1
   park_level_chk: assert property (@(posedge clk) disable iff (rst)
      dqs_oe_n |-> (dqs_o == DQS_PULL_UP));

   // R2
   read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
      rd_data_en |-> (dq_oe_n && !wr_beat_ack));

   // R3
   write_drive_chk: assert property (@(posedge clk) disable iff (rst)
      wr_beat_ack |-> (!dq_oe_n && !dqs_oe_n && dqs_o));

   // R4
   preamble_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(dq_oe_n) |-> $past(!dqs_oe_n && !dqs_o));

   // R6
   burst_end_chk: assert property (@(posedge clk) disable iff (rst)
      burst_end |-> (rd_data_en || wr_beat_ack));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      xfer_done |=> !xfer_done);

   // R9
   push_block_chk: assert property (@(posedge clk) disable iff (rst)
      !dqs_oe_n |-> !rd_fifo_push);

   // R10
   ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
      rd_fifo_pop |=> rd_ack);

   // R10
   ack_origin_chk: assert property (@(posedge clk) disable iff (rst)
      rd_ack |-> $past(rd_fifo_pop));

endmodule

bind ddr_data_phase_ctrl ddr_data_phase_ctrl_chk #(.DQS_PULL_UP(DQS_PULL_UP)) u_chk (.*);

// File: tb/ddr_data_phase_ctrl_test.sv
module ddr_data_phase_ctrl_test;

   localparam int SYS_DW = 64;
   localparam int DQ_W   = SYS_DW / 2;
   localparam int NP     = 2;
   localparam int TWR    = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic                rst = 1'b1;
   logic                data_en = 1'b0, op_is_read = 1'b0;
   logic                pend_valid = 1'b0, pend_is_read = 1'b0;
   logic [SYS_DW-1:0]   wr_data = '0;
   logic [SYS_DW/8-1:0] wr_be = '0;
   logic                dqs_cap = 1'b0;
   logic                rd_fifo_empty = 1'b1;
   logic [SYS_DW-1:0]   rd_fifo_data = '0;

   logic burst_end, xfer_done, wr_beat_ack, dq_oe_n, dqs_oe_n, dqs_o;
   logic rd_data_en, rd_fifo_push, rd_fifo_pop, rd_ack;
   logic [DQ_W-1:0] dq_hi, dq_lo;
   logic [3:0] dm_hi, dm_lo;
   logic [SYS_DW-1:0] rd_data;

   logic burst_end3, xfer_done3, wr_beat_ack3, dq_oe_n3, dqs_oe_n3, dqs_o3;
   logic rd_data_en3, rd_fifo_push3, rd_fifo_pop3, rd_ack3;
   logic [DQ_W-1:0] dq_hi3, dq_lo3;
   logic [3:0] dm_hi3, dm_lo3;
   logic [SYS_DW-1:0] rd_data3;

   ddr_data_phase_ctrl #(.SYS_DW(SYS_DW), .BURST_LEN(4), .CAS_LAT(2),
                         .TWR_CYC(TWR), .DQS_PULL_UP(1'b0)) uut (
      .clk(clk), .rst(rst), .data_en(data_en), .op_is_read(op_is_read),
      .pend_valid(pend_valid), .pend_is_read(pend_is_read),
      .burst_end(burst_end), .xfer_done(xfer_done), .wr_data(wr_data),
      .wr_be(wr_be), .wr_beat_ack(wr_beat_ack), .dq_hi(dq_hi), .dq_lo(dq_lo),
      .dm_hi(dm_hi), .dm_lo(dm_lo), .dq_oe_n(dq_oe_n), .dqs_oe_n(dqs_oe_n),
      .dqs_o(dqs_o), .rd_data_en(rd_data_en), .dqs_cap(dqs_cap),
      .rd_fifo_push(rd_fifo_push), .rd_fifo_empty(rd_fifo_empty),
      .rd_fifo_data(rd_fifo_data), .rd_fifo_pop(rd_fifo_pop),
      .rd_ack(rd_ack), .rd_data(rd_data));

   ddr_data_phase_ctrl #(.SYS_DW(SYS_DW), .BURST_LEN(4), .CAS_LAT(3),
                         .TWR_CYC(TWR), .DQS_PULL_UP(1'b1)) uut_cl3 (
      .clk(clk), .rst(rst), .data_en(data_en), .op_is_read(op_is_read),
      .pend_valid(1'b0), .pend_is_read(1'b0),
      .burst_end(burst_end3), .xfer_done(xfer_done3), .wr_data(wr_data),
      .wr_be(wr_be), .wr_beat_ack(wr_beat_ack3), .dq_hi(dq_hi3), .dq_lo(dq_lo3),
      .dm_hi(dm_hi3), .dm_lo(dm_lo3), .dq_oe_n(dq_oe_n3), .dqs_oe_n(dqs_oe_n3),
      .dqs_o(dqs_o3), .rd_data_en(rd_data_en3), .dqs_cap(dqs_cap),
      .rd_fifo_push(rd_fifo_push3), .rd_fifo_empty(rd_fifo_empty),
      .rd_fifo_data(rd_fifo_data), .rd_fifo_pop(rd_fifo_pop3),
      .rd_ack(rd_ack3), .rd_data(rd_data3));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic chk1(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic chkv(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // scoreboard: expected read-window start cycles and acknowledged words
   int                exp_rden_q[$];
   int                exp_rden3_q[$];
   logic [SYS_DW-1:0] exp_ack_q[$];
   logic              rden_prev = 1'b0, rden3_prev = 1'b0;

   always @(negedge clk) begin
      if (!rst) begin
         if (rd_data_en && !rden_prev) begin
            if (exp_rden_q.size() == 0) chk1("R2 unexpected read window (CL2)", 1'b1, 1'b0);
            else chkv("R2 read window start (CL2)", 64'(cyc), 64'(exp_rden_q.pop_front()));
         end
         if (rd_data_en3 && !rden3_prev) begin
            if (exp_rden3_q.size() == 0) chk1("R2 unexpected read window (CL3)", 1'b1, 1'b0);
            else chkv("R2 read window start (CL3)", 64'(cyc), 64'(exp_rden3_q.pop_front()));
         end
         if (rd_ack) begin
            if (exp_ack_q.size() == 0) chk1("R10 unexpected rd_ack", 1'b1, 1'b0);
            else chkv("R10 acknowledged word", rd_data, exp_ack_q.pop_front());
         end
      end
      rden_prev  = rd_data_en;
      rden3_prev = rd_data_en3;
   end

   task automatic at_cyc(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic run_read(input logic pv);
      int p;
      int len;
      bit inb;
      string tag;
      tag = pv ? "R7 chained read window" : "R2 read window";
      len = pv ? 2 * NP : NP;
      @(negedge clk);
      data_en = 1'b1; op_is_read = 1'b1; pend_valid = pv; pend_is_read = pv;
      p = cyc + 1;
      exp_rden_q.push_back(p + 2);
      exp_rden3_q.push_back(p + 3);
      @(negedge clk);
      data_en = 1'b0;
      for (int c = p; c < p + 2 + len + 2; c++) begin
         at_cyc(c);
         inb = (c >= p + 2) && (c < p + 2 + len);
         chk1(tag, rd_data_en, inb);
         chk1("R6 read burst_end", burst_end, inb && (((c - p - 2) % NP) == NP - 1));
         chk1(pv ? "R7 no done between chained bursts" : "R8 read done timing",
              xfer_done, c == p + 2 + len);
         chk1("R1 dqs parked low during read", dqs_o, 1'b0);
         if (c == p + 2) chk1("R2 CL3 window not yet open", rd_data_en3, 1'b0);
         if (c == p + 3) chk1("R2 CL3 window open", rd_data_en3, 1'b1);
         if (c == p + 3) chk1("R1 CL3 dqs parked high", dqs_o3, 1'b1);
         if (pv && c == p + 2 + NP) pend_valid = 1'b0;
      end
   endtask

   task automatic run_write(input logic pv, input logic pr);
      int q;
      logic [3:0] eh, el;
      @(negedge clk);
      data_en = 1'b1; op_is_read = 1'b0; pend_valid = pv; pend_is_read = pr;
      wr_data = 64'h0123_4567_89AB_CDEF; wr_be = 8'hFF;
      #1;
      chk1("R4 preamble dqs_oe_n", dqs_oe_n, 1'b0);
      chk1("R4 preamble dq_oe_n", dq_oe_n, 1'b1);
      chk1("R4 preamble dqs_o", dqs_o, 1'b0);
      q = cyc + 1;
      if (pv && pr) exp_rden_q.push_back(q + NP);
      for (int i = 0; i < NP; i++) begin
         @(negedge clk);
         data_en = 1'b0;
         chk1("R3 dq_oe_n during write", dq_oe_n, 1'b0);
         chk1("R3 dqs_oe_n during write", dqs_oe_n, 1'b0);
         chk1("R3 dqs_o during write", dqs_o, 1'b1);
         chk1("R3 wr_beat_ack", wr_beat_ack, 1'b1);
         wr_data = {32'hC0DE_0000 + 32'(i), 32'h5EED_0000 + 32'(3 * i)};
         wr_be   = 8'hA5 ^ 8'(i);
         if (i == 0) dqs_cap = 1'b1;
         #1;
         eh = ~wr_be[7:4];
         el = ~wr_be[3:0];
         chkv("R5 first beat upper half", 64'(dq_hi), 64'(wr_data[63:32]));
         chkv("R5 second beat lower half", 64'(dq_lo), 64'(wr_data[31:0]));
         chkv("R5 upper masks", 64'(dm_hi), 64'(eh));
         chkv("R5 lower masks", 64'(dm_lo), 64'(el));
         chk1("R6 write burst_end", burst_end, i == NP - 1);
         if (i == 0) begin
            chk1("R9 push blocked while driving DQS", rd_fifo_push, 1'b0);
            dqs_cap = 1'b0;
         end
      end
      if (!pv) begin
         for (int k = 0; k < TWR; k++) begin
            @(negedge clk);
            chk1("R8 write done after recovery", xfer_done, k == TWR - 1);
            chk1("R3 drivers released after burst", dq_oe_n, 1'b1);
            chk1("R1 dqs released after burst", dqs_oe_n, 1'b1);
         end
         @(negedge clk);
         chk1("R8 done is one pulse", xfer_done, 1'b0);
      end else begin
         @(negedge clk);
         pend_valid = 1'b0;
         chk1("R7 read follows write with no gap", rd_data_en, 1'b1);
         chk1("R7 drivers off in chained read", dq_oe_n, 1'b1);
         chk1("R7 no done between bursts", xfer_done, 1'b0);
         at_cyc(q + 2 * NP);
         chk1("R7 done after chained read", xfer_done, 1'b1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk1("R1 reset dq_oe_n", dq_oe_n, 1'b1);
      chk1("R1 reset dqs_oe_n", dqs_oe_n, 1'b1);
      chk1("R1 reset dqs_o pull-down", dqs_o, 1'b0);
      chk1("R1 reset dqs_o pull-up", dqs_o3, 1'b1);
      chk1("R1 reset rd_data_en", rd_data_en, 1'b0);
      chk1("R8 reset xfer_done", xfer_done, 1'b0);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      run_read(1'b0);
      repeat (6) @(negedge clk);
      run_write(1'b0, 1'b0);
      repeat (6) @(negedge clk);
      run_read(1'b1);
      repeat (6) @(negedge clk);
      run_write(1'b1, 1'b1);
      repeat (8) @(negedge clk);

      dqs_cap = 1'b1;
      #1;
      chk1("R9 captured strobe pushes when idle", rd_fifo_push, 1'b1);
      dqs_cap = 1'b0;

      @(negedge clk);
      rd_fifo_empty = 1'b0; rd_fifo_data = 64'hFEED_FACE_0000_0001;
      exp_ack_q.push_back(rd_fifo_data);
      #1 chk1("R10 pop when not empty", rd_fifo_pop, 1'b1);
      @(negedge clk);
      rd_fifo_data = 64'h1234_0000_ABCD_0002;
      exp_ack_q.push_back(rd_fifo_data);
      #1 chk1("R10 pop back to back", rd_fifo_pop, 1'b1);
      @(negedge clk);
      rd_fifo_empty = 1'b1;
      #1 chk1("R10 no pop when empty", rd_fifo_pop, 1'b0);
      @(negedge clk);
      chk1("R10 ack drops after empty", rd_ack, 1'b0);

      repeat (4) @(negedge clk);
      chkv("R2 all CL2 windows seen", 64'(exp_rden_q.size()), 64'd0);
      chkv("R2 all CL3 windows seen", 64'(exp_rden3_q.size()), 64'd0);
      chkv("R10 all words acknowledged", 64'(exp_ack_q.size()), 64'd0);

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule